// File: doc/BRIEF.md
# Endpoint Base Address Register Bank with Address Decode

This block holds the base address registers that an endpoint exposes in its configuration space, and it decodes incoming addresses against them. A host sizes each region in the usual way. It writes all ones to a register, reads the value back, masks off the attribute bits, then inverts the result and adds one. After that it writes a base aligned to the region size. Address bits below the region size are tied to zero, so the read-back shows the size directly. The low attribute bits are fixed by parameters and cannot be written. They give the region type (memory or I/O), the address width, and whether the region is prefetchable.

Each slot is set by parameters to one of five kinds: unused, 32-bit memory, the lower half of a 64-bit memory pair, the upper half of such a pair, or I/O. A 64-bit region takes two consecutive slots and decodes as one 64-bit base. Lookups name an address and a space, either memory or I/O. One cycle later the block returns a hit flag, the index of the lowest-numbered slot that matched, and the offset inside that region. The memory and I/O enable bits of the command register come in as plain inputs and gate the decode.

Top module: `cfg_bar_bank`

## Requirements
- R1: Bit 0 of every decoding slot is read-only. It reads 1 for an I/O slot and 0 for a memory slot, whatever is written.
- R2: For a memory slot, bits 2:1 read 00 for a 32-bit region and 10 for the lower half of a 64-bit pair. Bit 3 reads the prefetchable attribute. Writes change none of these bits.
- R3: After all ones are written with every byte enabled, the read-back gives the region size. Mask the low 4 bits (memory) or low 2 bits (I/O), invert, and add one. With the default parameters, slot 0 (4 KB) then reads 0xFFFFF000.
- R4: Bits below log2 of the region size read as zero and ignore writes. An aligned base reads back unchanged, apart from the attribute bits.
- R5: The slot above a 64-bit lower half is fully writable and supplies address bits 63:32 of the pair's base. An address whose upper word does not match does not hit.
- R6: A configuration write changes only the bytes whose enable bit is set.
- R7: After reset every base is zero, and each slot reads back only its attribute bits.
- R8: A memory lookup hits only while the memory enable is set. An I/O lookup hits only while the I/O enable is set. Unused and upper-half slots never hit, and slot indices beyond the bank read zero.
- R9: A lookup presented in one cycle is answered in the next cycle. It is a hit exactly when base ≤ address ≤ base + size − 1 in the matching space. The response then carries the slot index and the offset (address − base).
- R10: When regions overlap, the lowest-numbered matching slot is reported.
- R11: A 32-bit memory or I/O slot never hits an address with a nonzero upper word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Slot index for configuration read and write |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected slot (combinational) |
| cmd_mem_en | input | 1 | Memory space decode enable |
| cmd_io_en | input | 1 | I/O space decode enable |
| req_valid | input | 1 | Lookup request |
| req_is_io | input | 1 | Lookup is in I/O space (1) or memory space (0) |
| req_addr | input | 64 | Lookup address |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | The address hit a slot |
| rsp_bar | output | SEL_W | Index of the slot that hit |
| rsp_offset | output | 64 | Offset within the region |

## Verification
The bench goes after these corner cases:
- **First and last bytes of a region, and the byte just past its end.** A design with an off-by-one limit would drop the last byte or claim the next one.
- **Unaligned and byte-masked writes.** A design that let low bits through would shift the decoded base, and one that ignored the enables would corrupt neighbouring bytes.
- **64-bit pairs with a mismatched upper word, and 32-bit slots given addresses above 4 GB.** A design that compared only the low word would report false hits.
- **Overlapping regions, cleared enables, and lookups in the wrong space.** A design with reversed priority or missing gating would name the wrong slot or hit when it must not.

// File: rtl/cfg_bar_pkg.sv
package cfg_bar_pkg;

  typedef enum logic [2:0] {
    BK_NONE  = 3'd0,
    BK_MEM32 = 3'd1,
    BK_MEM64 = 3'd2,
    BK_IO    = 3'd3,
    BK_UPPER = 3'd4
  } bar_kind_e;

  // Region size after the minimum for the slot kind is applied.
  function automatic int unsigned eff_szlog2(bar_kind_e k, int unsigned szlog2);
    case (k)
      BK_MEM32, BK_MEM64: return (szlog2 < 4) ? 4 : szlog2;
      BK_IO:              return (szlog2 < 2) ? 2 : szlog2;
      default:            return 0;
    endcase
  endfunction

  function automatic logic [31:0] writable_mask(bar_kind_e k, int unsigned szlog2);
    case (k)
      BK_MEM32, BK_MEM64, BK_IO: return ~((32'd1 << eff_szlog2(k, szlog2)) - 32'd1);
      BK_UPPER:                  return 32'hFFFF_FFFF;
      default:                   return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] attr_bits(bar_kind_e k, logic pref);
    case (k)
      BK_IO:    return 32'h1;
      BK_MEM32: return {28'd0, pref, 3'b000};
      BK_MEM64: return {28'd0, pref, 3'b100};
      default:  return 32'h0;
    endcase
  endfunction

  function automatic logic [63:0] window_mask(bar_kind_e k, int unsigned szlog2);
    return (64'd1 << eff_szlog2(k, szlog2)) - 64'd1;
  endfunction

  function automatic logic decodes(bar_kind_e k);
    return (k == BK_MEM32) || (k == BK_MEM64) || (k == BK_IO);
  endfunction

endpackage

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot
  import cfg_bar_pkg::*;
#(
  parameter bar_kind_e   KIND   = BK_NONE,
  parameter int unsigned SZLOG2 = 12,
  parameter bit          PREF   = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] rd_value,
  output logic [31:0] base_bits
);

  localparam logic [31:0] WMASK = writable_mask(KIND, SZLOG2);
  localparam logic [31:0] ATTR  = attr_bits(KIND, PREF);

  logic [31:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < 4; b++) begin
        if (be[b]) held_q[b*8 +: 8] <= wdata[b*8 +: 8] & WMASK[b*8 +: 8];
      end
    end
  end

  assign base_bits = held_q;
  assign rd_value  = held_q | ATTR;

  // Sizing read-back after an all-ones write
  assert_sizing_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && be == 4'hF && wdata == 32'hFFFF_FFFF) |=> (rd_value == (WMASK | ATTR)));

  // A disabled byte lane keeps its value
  assert_byte0_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !be[0]) |=> (rd_value[7:0] == $past(rd_value[7:0])));

  assert_byte3_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !be[3]) |=> (rd_value[31:24] == $past(rd_value[31:24])));

  // Without a write the register is stable
  assert_hold_without_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_value));

endmodule

// File: rtl/cfg_bar_match.sv
module cfg_bar_match
  import cfg_bar_pkg::*;
#(
  parameter bar_kind_e   KIND   = BK_NONE,
  parameter int unsigned SZLOG2 = 12
) (
  input  logic [63:0] base,
  input  logic        req_is_io,
  input  logic [63:0] req_addr,
  input  logic        mem_en,
  input  logic        io_en,
  output logic        hit,
  output logic [63:0] offset
);

  localparam logic [63:0] WIN     = window_mask(KIND, SZLOG2);
  localparam bit          ACTIVE  = decodes(KIND);
  localparam bit          IS_IO   = (KIND == BK_IO);

  logic space_ok;

  always_comb begin
    space_ok = IS_IO ? (req_is_io && io_en) : (!req_is_io && mem_en);
    hit      = ACTIVE && space_ok && ((req_addr & ~WIN) == base);
    offset   = req_addr & WIN;
  end

endmodule

// File: rtl/cfg_bar_bank.sv
module cfg_bar_bank
  import cfg_bar_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 6,
  // 3 bits per slot, slot 0 in the low bits (values of bar_kind_e)
  parameter logic [NUM_SLOTS*3-1:0] SLOT_KIND   = {3'd0, 3'd1, 3'd3, 3'd4, 3'd2, 3'd1},
  // 5 bits per slot: log2 of the region size in bytes
  parameter logic [NUM_SLOTS*5-1:0] SLOT_SZLOG2 = {5'd0, 5'd16, 5'd8, 5'd0, 5'd20, 5'd12},
  parameter logic [NUM_SLOTS-1:0]   SLOT_PREF   = 6'b010010,
  localparam int unsigned SEL_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [3:0]       cfg_be,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             cmd_mem_en,
  input  logic             cmd_io_en,
  input  logic             req_valid,
  input  logic             req_is_io,
  input  logic [63:0]      req_addr,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [SEL_W-1:0] rsp_bar,
  output logic [63:0]      rsp_offset
);

  logic [31:0]          rd_value  [NUM_SLOTS];
  logic [31:0]          base_bits [NUM_SLOTS];
  logic [63:0]          base64    [NUM_SLOTS];
  logic [63:0]          offset_w  [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] hit_vec;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    localparam bar_kind_e   K_I  = bar_kind_e'(SLOT_KIND[3*i +: 3]);
    localparam int unsigned SZ_I = int'(SLOT_SZLOG2[5*i +: 5]);

    cfg_bar_slot #(.KIND(K_I), .SZLOG2(SZ_I), .PREF(SLOT_PREF[i])) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_we && (cfg_sel == SEL_W'(i))),
      .be        (cfg_be),
      .wdata     (cfg_wdata),
      .rd_value  (rd_value[i]),
      .base_bits (base_bits[i])
    );

    if (K_I == BK_MEM64 && i + 1 < NUM_SLOTS) begin : g_pair
      assign base64[i] = {base_bits[i+1], base_bits[i]};
    end else begin : g_single
      assign base64[i] = {32'd0, base_bits[i]};
    end

    cfg_bar_match #(.KIND(K_I), .SZLOG2(SZ_I)) u_match (
      .base      (base64[i]),
      .req_is_io (req_is_io),
      .req_addr  (req_addr),
      .mem_en    (cmd_mem_en),
      .io_en     (cmd_io_en),
      .hit       (hit_vec[i]),
      .offset    (offset_w[i])
    );
  end

  // Configuration read mux; indices past the bank read zero
  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (cfg_sel == SEL_W'(i)) cfg_rdata = rd_value[i];
    end
  end

  // Lowest index wins
  logic             pick_found;
  logic [SEL_W-1:0] pick_idx;
  logic [63:0]      pick_off;

  always_comb begin
    pick_found = 1'b0;
    pick_idx   = '0;
    pick_off   = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        pick_found = 1'b1;
        pick_idx   = SEL_W'(i);
        pick_off   = offset_w[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_bar    <= '0;
      rsp_offset <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_hit    <= req_valid && pick_found;
      rsp_bar    <= pick_found ? pick_idx : '0;
      rsp_offset <= pick_found ? pick_off : '0;
    end
  end

  // Named events for the checks below
  logic             lookup_hit_w;
  logic [NUM_SLOTS-1:0] lower_hits_w;
  logic [2:0]       rsp_kind_w;
  logic [4:0]       rsp_szlog2_w;

  assign lookup_hit_w = req_valid && pick_found;
  assign lower_hits_w = hit_vec & ((NUM_SLOTS'(1) << pick_idx) - NUM_SLOTS'(1));
  assign rsp_kind_w   = SLOT_KIND[3*rsp_bar +: 3];

  always_comb begin
    rsp_szlog2_w = SLOT_SZLOG2[5*rsp_bar +: 5];
    if (rsp_kind_w == 3'(BK_IO) && rsp_szlog2_w < 5'd2) rsp_szlog2_w = 5'd2;
    else if (rsp_kind_w != 3'(BK_IO) && rsp_szlog2_w < 5'd4) rsp_szlog2_w = 5'd4;
  end

  assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_offset_in_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> ((rsp_offset >> rsp_szlog2_w) == 64'd0));

  assert_hit_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> ($past(req_is_io) ? $past(cmd_io_en) : $past(cmd_mem_en)));

  assert_hit_on_decoder_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_kind_w == 3'(BK_MEM32) || rsp_kind_w == 3'(BK_MEM64) ||
                 rsp_kind_w == 3'(BK_IO)));

  assert_lowest_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_hit_w |-> (lower_hits_w == '0));

  assert_hit_only_on_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

endmodule

// File: tb/sim_cfg_bar_bank.sv
module sim_cfg_bar_bank;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        cmd_mem_en, cmd_io_en;
  logic        req_valid, req_is_io;
  logic [63:0] req_addr;
  logic        rsp_valid, rsp_hit;
  logic [2:0]  rsp_bar;
  logic [63:0] rsp_offset;

  always #2 clk = ~clk;   // 250 MHz

  cfg_bar_bank u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cmd_mem_en(cmd_mem_en),
    .cmd_io_en(cmd_io_en), .req_valid(req_valid), .req_is_io(req_is_io),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_bar(rsp_bar), .rsp_offset(rsp_offset)
  );

  // Bench view of the default configuration: 0 none, 1 mem32, 2 mem64 low, 3 io, 4 upper
  localparam int KIND [6] = '{1, 2, 4, 3, 1, 0};
  localparam int SZ   [6] = '{12, 20, 0, 8, 16, 0};
  localparam int PREF [6] = '{0, 1, 0, 0, 1, 0};

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  logic [31:0] m [6];

  function automatic logic [31:0] b_attr(int s);
    if (KIND[s] == 3) return 32'h1;
    if (KIND[s] == 1) return PREF[s] ? 32'h8 : 32'h0;
    if (KIND[s] == 2) return PREF[s] ? 32'hC : 32'h4;
    return 32'h0;
  endfunction

  function automatic logic [31:0] b_mask(int s);
    if (KIND[s] == 4) return 32'hFFFF_FFFF;
    if (KIND[s] == 0) return 32'h0;
    return 32'hFFFF_FFFF << SZ[s];
  endfunction

  function automatic logic [31:0] b_read(int s);
    return (s < 6) ? (m[s] | b_attr(s)) : 32'h0;
  endfunction

  function automatic logic [63:0] b_base(int s);
    return (KIND[s] == 2) ? {m[s+1], m[s]} : {32'h0, m[s]};
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(int s, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 3'(s); cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (s < 6)
      for (int b = 0; b < 4; b++)
        if (be[b]) m[s][b*8 +: 8] = d[b*8 +: 8] & b_mask(s)[b*8 +: 8];
  endtask

  task automatic cfg_check(int s, string req);
    @(negedge clk);
    cfg_sel = 3'(s);
    #1;
    check(cfg_rdata == b_read(s), req, $sformatf("read slot %0d", s),
          64'(cfg_rdata), 64'(b_read(s)));
  endtask

  task automatic lookup(bit io, logic [63:0] a, string req);
    bit eh = 0; int eb = 0; logic [63:0] eo = 0;
    for (int i = 0; i < 6; i++) begin
      if (!eh && (KIND[i] == 1 || KIND[i] == 2 || KIND[i] == 3)) begin
        logic [63:0] lo = b_base(i);
        logic [63:0] hi = lo + (64'd1 << SZ[i]) - 64'd1;
        bit sp = (KIND[i] == 3) ? (io && cmd_io_en) : (!io && cmd_mem_en);
        if (sp && a >= lo && a <= hi) begin eh = 1; eb = i; eo = a - lo; end
      end
    end
    @(negedge clk);
    req_valid = 1; req_is_io = io; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    check(rsp_valid == 1'b1, "R9", "rsp_valid", 64'(rsp_valid), 64'd1);
    check(rsp_hit == eh, req, $sformatf("hit for %h", a), 64'(rsp_hit), 64'(eh));
    if (eh) begin
      check(rsp_bar == 3'(eb), req, "bar index", 64'(rsp_bar), 64'(eb));
      check(rsp_offset == eo, req, "offset", rsp_offset, eo);
    end
  endtask

  function automatic logic [31:0] size_of(logic [31:0] rd, logic [31:0] attr_mask);
    return ~(rd & ~attr_mask) + 32'd1;
  endfunction

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 6; i++) m[i] = 0;
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_be = 0; cfg_wdata = 0;
    cmd_mem_en = 0; cmd_io_en = 0; req_valid = 0; req_is_io = 0; req_addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R7 / R1 / R2: reset read-back shows attributes only
    check(rsp_valid == 1'b0, "R7", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    for (int s = 0; s < 8; s++) cfg_check(s, (s < 6) ? "R7" : "R8");
    @(negedge clk); cfg_sel = 3; #1;
    check(cfg_rdata[0] == 1'b1, "R1", "io type bit", 64'(cfg_rdata[0]), 64'd1);
    cfg_sel = 1; #1;
    check(cfg_rdata[3:0] == 4'hC, "R2", "mem64 prefetch attr", 64'(cfg_rdata[3:0]), 64'hC);

    // R3: sizing
    for (int s = 0; s < 6; s++) cfg_write(s, 4'hF, 32'hFFFF_FFFF);
    @(negedge clk); cfg_sel = 0; #1;
    check(cfg_rdata == 32'hFFFF_F000, "R3", "slot0 all-ones", 64'(cfg_rdata), 64'hFFFF_F000);
    check(size_of(cfg_rdata, 32'hF) == 32'h1000, "R3", "slot0 size", 64'(size_of(cfg_rdata, 32'hF)), 64'h1000);
    cfg_sel = 1; #1;
    check(size_of(cfg_rdata, 32'hF) == 32'h10_0000, "R3", "slot1 size", 64'(size_of(cfg_rdata, 32'hF)), 64'h10_0000);
    cfg_sel = 3; #1;
    check(size_of(cfg_rdata, 32'h3) == 32'h100, "R3", "io size", 64'(size_of(cfg_rdata, 32'h3)), 64'h100);
    cfg_sel = 4; #1;
    check(size_of(cfg_rdata, 32'hF) == 32'h1_0000, "R3", "slot4 size", 64'(size_of(cfg_rdata, 32'hF)), 64'h1_0000);
    cfg_sel = 2; #1;
    check(cfg_rdata == 32'hFFFF_FFFF, "R5", "upper fully writable", 64'(cfg_rdata), 64'hFFFF_FFFF);
    cfg_check(5, "R8");

    // R1: attempt to clear type bit
    cfg_write(3, 4'hF, 32'h0);
    cfg_check(3, "R1");
    // R6: single byte lane
    cfg_write(4, 4'b0100, 32'hAABB_CCDD);
    cfg_check(4, "R6");
    @(negedge clk); cfg_sel = 4; #1;
    check(cfg_rdata == 32'hFFBB_0008, "R6", "byte lane 2 only", 64'(cfg_rdata), 64'hFFBB_0008);
    cfg_write(2, 4'b0010, 32'h0000_5500);
    cfg_check(2, "R6");

    // R4: aligned and unaligned bases
    cfg_write(0, 4'hF, 32'h1234_5678);
    @(negedge clk); cfg_sel = 0; #1;
    check(cfg_rdata == 32'h1234_5000, "R4", "unaligned low bits dropped", 64'(cfg_rdata), 64'h1234_5000);
    cfg_write(0, 4'hF, 32'h1010_0000);
    cfg_check(0, "R4");
    cfg_write(1, 4'hF, 32'h4000_0000);
    cfg_write(2, 4'hF, 32'h0000_0001);
    cfg_write(3, 4'hF, 32'h0000_1234);
    @(negedge clk); cfg_sel = 3; #1;
    check(cfg_rdata == 32'h0000_1201, "R4", "io base aligned", 64'(cfg_rdata), 64'h1201);
    cfg_write(4, 4'hF, 32'h2000_0000);

    // R9 boundaries
    cmd_mem_en = 1; cmd_io_en = 1;
    lookup(0, 64'h1010_0000, "R9");
    lookup(0, 64'h1010_0FFF, "R9");
    lookup(0, 64'h1010_1000, "R9");
    lookup(0, 64'h100F_FFFF, "R9");
    lookup(1, 64'h0000_12FF, "R9");
    lookup(1, 64'h0000_1300, "R9");
    // R5: 64-bit pair
    lookup(0, 64'h1_4000_0123, "R5");
    lookup(0, 64'h1_400F_FFFF, "R5");
    lookup(0, 64'h0_4000_0123, "R5");
    lookup(0, 64'h2_4000_0123, "R5");
    // R8: space and enable gating
    lookup(1, 64'h1010_0000, "R8");
    lookup(0, 64'h0000_1200, "R8");
    cmd_mem_en = 0;
    lookup(0, 64'h1010_0010, "R8");
    lookup(1, 64'h0000_1210, "R8");
    cmd_mem_en = 1; cmd_io_en = 0;
    lookup(1, 64'h0000_1210, "R8");
    cmd_io_en = 1;
    // R11: upper word on 32-bit slots
    lookup(0, 64'h1_1010_0000, "R11");
    lookup(1, 64'h1_0000_1200, "R11");
    // R10: overlap
    cfg_write(4, 4'hF, 32'h1010_0000);
    lookup(0, 64'h1010_0010, "R10");
    @(negedge clk);
    check(rsp_bar == 3'd0, "R10", "overlap picks slot 0", 64'(rsp_bar), 64'd0);
    lookup(0, 64'h1010_2000, "R10");

    // Random mix, checked against the bench model
    for (int it = 0; it < 400; it++) begin
      if ($urandom_range(7) == 0) begin
        int s = $urandom_range(7);
        cfg_write(s, 4'($urandom_range(15)), $urandom);
        cfg_check(s, "R6");
      end else begin
        int s;
        logic [63:0] a;
        bit io;
        do s = $urandom_range(4); while (KIND[s] == 4);
        cmd_mem_en = ($urandom_range(7) != 0);
        cmd_io_en  = ($urandom_range(7) != 0);
        a = b_base(s) + (64'd1 << SZ[s]) * 64'($urandom_range(1)) - 64'd8 + 64'($urandom_range(15));
        if ($urandom_range(1)) a = b_base(s) + 64'($urandom_range((1 << SZ[s]) - 1));
        if ($urandom_range(7) == 0) a = {32'($urandom_range(3)), $urandom};
        io = (KIND[s] == 3) ? ($urandom_range(4) != 0) : ($urandom_range(4) == 0);
        lookup(io, a, "R9");
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule